// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A watchdog timer that sits on a simple 32-bit register bus and is clocked from a slow reference, nominally 32768 Hz. Software programs a prescaler divisor and a 16-bit reload count into staging registers. It then sets an enable bit, and it proves it is alive by toggling 2-bit groups in a refresh register. If the down-counter runs out before software refreshes it, the block raises a one-cycle reset request and starts the next period on its own.

Every bus write must carry a fixed 16-bit key in its upper half. A write without the key is dropped, so a stray store cannot stop, retune or feed the watchdog. The divisor and the reload count written by software are only staged. The prescaler adopts the divisor when software toggles the configuration-commit group of the refresh register. The counter adopts the count when software toggles the counter-reload group. With a 32768 Hz reference, the timeout in seconds is the load value times the divisor, divided by 32768.

Top module: `kwdt_top`

## Requirements
- R1: A write takes effect only when bits 31:16 of the write data equal 0x1234. Any other upper half leaves every register unchanged.
- R2: The registers sit at these addresses: configuration 0x04, load 0x08, refresh 0x18, start 0x1C. A read returns the register's low 16 bits with zeros in bits 31:16, and any other address reads 0. Read data appears one clock after the address is presented.
- R3: After reset, the configuration register reads 0x0F00 (divisor 16), the load register reads 0xFFFF, the refresh and start registers read 0, and the reset request is low.
- R4: Configuration bits 15:8 hold the divisor minus one, and the load register holds a 16-bit count. A write to either register does not change the running timeout until a commit or reload group fires.
- R5: A refresh group fires only when the value written to it is 01 or 10 and differs from the value it held before. Writing 00, writing 11, or writing the same value again does not fire the group, but the written value is still stored and read back.
- R6: When group bits 5:4 fire, the prescaler adopts the staged divisor and restarts its phase at zero. When group bits 3:2 fire, the counter adopts the staged load value and restarts from it. Group bits 1:0 never affect counting.
- R7: Start bit 0 set to 1 enables counting. Clearing it freezes both the prescaler and the counter where they are, and setting it again resumes from that point.
- R8: With load L (L ≥ 1) and divisor field D, the reset request goes high for exactly one cycle L×(D+1) clock edges after counting begins. The counter then reloads from the committed load value and the period repeats.
- R9: Firing the reload and commit groups while the counter is running restarts a full L×(D+1) period from the refresh write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (5) | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data: key in upper half, data in lower half |
| bus_rdata | output | DATA_W (32) | Registered read data |
| wdt_rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, 5-bit addresses, a 16-bit counter and an 8-bit divisor field. At run time it programs divisors of 2 and 1 with loads of 5 and 3, so each expiry comes within a few tens of cycles. It also leaves the reset divisor of 16 and the load of 0xFFFF in force for one window to show that staged values stay inactive until committed. Those small runtime values make every case reachable in a short run: repeated expiries, a kick while running, pausing and resuming mid-period, and the smallest divisor.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [15:0] WR_KEY   = 16'h1234;
  localparam logic [7:0]  OFF_CFG  = 8'h04;
  localparam logic [7:0]  OFF_LOAD = 8'h08;
  localparam logic [7:0]  OFF_REFR = 8'h18;
  localparam logic [7:0]  OFF_RUN  = 8'h1C;
  localparam int          DIV_LSB  = 8;
  localparam int          N_GROUPS = 3;
  // group indices within the refresh register
  localparam int          GRP_COMMIT = 2;
  localparam int          GRP_RELOAD = 1;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 8,
  parameter int CNT_W   = 16,
  parameter int DIV_RST = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DIV_W-1:0]  div_staged,
  output logic [CNT_W-1:0]  load_staged,
  output logic              run,
  output logic              commit_p,
  output logic              reload_p
);
  import kwdt_pkg::*;
  localparam int HALF = DATA_W / 2;
  localparam int REFR_W = 2 * N_GROUPS;
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFF_LOAD);
  localparam logic [ADDR_W-1:0] A_REFR = ADDR_W'(OFF_REFR);
  localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(OFF_RUN);
  localparam logic [HALF-1:0] CFG_RST = HALF'(DIV_RST) << DIV_LSB;

  logic [HALF-1:0]   cfg_q;
  logic [CNT_W-1:0]  load_q;
  logic [REFR_W-1:0] refr_q;
  logic              run_q;
  logic              key_ok, wr_ok;
  logic [HALF-1:0]   wlow;
  logic [1:0]        fire;

  assign key_ok = bus_wdata[DATA_W-1:HALF] == HALF'(WR_KEY);
  assign wr_ok  = bus_we && key_ok;
  assign wlow   = bus_wdata[HALF-1:0];

  // one detector per group that drives an action
  for (genvar g = 1; g < N_GROUPS; g++) begin : g_fire
    logic [1:0] nv, ov;
    assign nv = wlow[2*g+1:2*g];
    assign ov = refr_q[2*g+1:2*g];
    assign fire[g-1] = wr_ok && (bus_addr == A_REFR) &&
                       (nv == 2'b01 || nv == 2'b10) && (nv != ov);
  end

  assign commit_p = fire[GRP_COMMIT-1];
  assign reload_p = fire[GRP_RELOAD-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= CFG_RST;
      load_q <= '1;
      refr_q <= '0;
      run_q  <= 1'b0;
    end else if (wr_ok) begin
      case (bus_addr)
        A_CFG:   cfg_q  <= wlow;
        A_LOAD:  load_q <= wlow[CNT_W-1:0];
        A_REFR:  refr_q <= wlow[REFR_W-1:0];
        A_RUN:   run_q  <= wlow[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_CFG:   bus_rdata <= DATA_W'(cfg_q);
        A_LOAD:  bus_rdata <= DATA_W'(load_q);
        A_REFR:  bus_rdata <= DATA_W'(refr_q);
        A_RUN:   bus_rdata <= DATA_W'(run_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign div_staged  = cfg_q[DIV_LSB+DIV_W-1:DIV_LSB];
  assign load_staged = load_q;
  assign run         = run_q;

  // R1
  key_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !key_ok) |=> ($stable(cfg_q) && $stable(load_q) &&
                             $stable(refr_q) && $stable(run_q)));
endmodule

// File: rtl/kwdt_presc.sv
module kwdt_presc #(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             commit,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] div_act, phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_act <= DIV_W'(DIV_RST);
      phase   <= '0;
    end else if (commit) begin
      div_act <= div_in;
      phase   <= '0;
    end else if (en) begin
      phase <= (phase == div_act) ? '0 : phase + DIV_W'(1);
    end
  end

  assign tick = en && (phase == div_act);

  // R6
  phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= div_act);
  // R6
  commit_load_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (div_act == $past(div_in) && phase == '0));
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_in,
  output logic             expire
);
  logic [CNT_W-1:0] load_act, count;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_act <= '1;
      count    <= '1;
      expire   <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (reload) begin
        load_act <= load_in;
        count    <= load_in;
      end else if (tick) begin
        if (count <= CNT_W'(1)) begin
          count  <= load_act;
          expire <= 1'b1;
        end else begin
          count <= count - CNT_W'(1);
        end
      end
    end
  end

  // R7
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !reload) |=> $stable(count));
  // R8
  req_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    expire |-> $past(en));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 8,
  parameter int CNT_W   = 16,
  parameter int DIV_RST = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_req
);
  logic [DIV_W-1:0] div_staged;
  logic [CNT_W-1:0] load_staged;
  logic run, commit_p, reload_p, tick;

  kwdt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
    .CNT_W(CNT_W), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .div_staged(div_staged), .load_staged(load_staged), .run(run),
    .commit_p(commit_p), .reload_p(reload_p)
  );

  kwdt_presc #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_presc (
    .clk(clk), .rst(rst), .en(run), .commit(commit_p),
    .div_in(div_staged), .tick(tick)
  );

  kwdt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .en(run), .tick(tick), .reload(reload_p),
    .load_in(load_staged), .expire(wdt_rst_req)
  );
endmodule

// File: tb/kwdt_top_test.sv
module kwdt_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CFG = 5'h04, A_LOAD = 5'h08,
                         A_REFR = 5'h18, A_RUN = 5'h1C;

  logic clk = 1'b0, rst = 1'b1, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic wdt_rst_req;

  int cyc = 0, n_chk = 0, n_fail = 0, n_pulse = 0;
  int expq[$];
  bit done = 0;

  kwdt_top uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: every reset-request pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && wdt_rst_req) begin
      n_pulse++;
      if (expq.size() == 0) chk(0, "R8 unexpected reset request at cycle", cyc, -1);
      else begin
        int e;
        e = expq.pop_front();
        chk(cyc == e, "R8/R9 reset request cycle", cyc, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d,
                    input logic [15:0] key, output int edge_n);
    @(negedge clk);
    bus_addr = a; bus_wdata = {key, d}; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    edge_n = cyc;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int s, t1, t2, k, pc;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R3 reset state
    rd(A_CFG, v);  chk(v == 32'h0F00, "R3 cfg after reset", v, 32'h0F00);
    rd(A_LOAD, v); chk(v == 32'hFFFF, "R3 load after reset", v, 32'hFFFF);
    rd(A_REFR, v); chk(v == 0, "R3 refresh after reset", v, 0);
    rd(A_RUN, v);  chk(v == 0, "R3 start after reset", v, 0);
    chk(wdt_rst_req == 0, "R3 request low after reset", wdt_rst_req, 0);
    // R2 unmapped address
    rd(5'h10, v);  chk(v == 0, "R2 unmapped read", v, 0);

    // R1 bad key ignored
    wr(A_LOAD, 16'h0005, 16'hABCD, s);
    rd(A_LOAD, v); chk(v == 32'hFFFF, "R1 load keeps value on bad key", v, 32'hFFFF);
    wr(A_RUN, 16'h0001, 16'h1235, s);
    rd(A_RUN, v);  chk(v == 0, "R1 start keeps value on bad key", v, 0);

    // R2/R4 staging registers
    wr(A_LOAD, 16'h0005, 16'h1234, s);
    wr(A_CFG, 16'h0100, 16'h1234, s);
    rd(A_LOAD, v); chk(v == 32'h0005, "R2 load readback", v, 5);
    rd(A_CFG, v);  chk(v == 32'h0100, "R2 cfg readback", v, 32'h100);

    // R4/R6 only interrupt group toggled: staged values stay inactive
    pc = n_pulse;
    wr(A_REFR, 16'h0001, 16'h1234, s);
    wr(A_RUN, 16'h0001, 16'h1234, s);
    wait_to(s + 40);
    wr(A_RUN, 16'h0000, 16'h1234, s);
    chk(n_pulse == pc, "R4 staged values not yet active", n_pulse - pc, 0);

    // R6/R8 commit + reload, two periods of 5*2
    wr(A_REFR, 16'h0015, 16'h1234, s);
    rd(A_REFR, v); chk(v == 32'h15, "R5 refresh readback", v, 32'h15);
    pc = n_pulse;
    wr(A_RUN, 16'h0001, 16'h1234, s);
    expq.push_back(s + 10); expq.push_back(s + 20);
    wait_to(s + 25);
    wr(A_RUN, 16'h0000, 16'h1234, t1);
    chk(n_pulse - pc == 2, "R8 repeating expiry count", n_pulse - pc, 2);

    // R9 kick while running
    wr(A_REFR, 16'h0029, 16'h1234, s);
    wr(A_RUN, 16'h0001, 16'h1234, s);
    wait_to(s + 6);
    wr(A_REFR, 16'h0015, 16'h1234, k);
    expq.push_back(k + 10);
    wait_to(k + 12);
    wr(A_RUN, 16'h0000, 16'h1234, t1);

    // R5 writes of 11, same value, 00 do not reload
    wr(A_REFR, 16'h0029, 16'h1234, s);
    wr(A_RUN, 16'h0001, 16'h1234, s);
    expq.push_back(s + 10);
    wait_to(s + 3);
    wr(A_REFR, 16'h002D, 16'h1234, t1);
    wr(A_REFR, 16'h002D, 16'h1234, t1);
    wr(A_REFR, 16'h0021, 16'h1234, t1);
    wait_to(s + 12);
    wr(A_RUN, 16'h0000, 16'h1234, t1);
    rd(A_REFR, v); chk(v == 32'h21, "R5 non-firing value stored", v, 32'h21);

    // R7 pause and resume (also 00->01 fires reload)
    wr(A_REFR, 16'h0015, 16'h1234, s);
    wr(A_RUN, 16'h0001, 16'h1234, s);
    wait_to(s + 3);
    wr(A_RUN, 16'h0000, 16'h1234, t1);
    wait_to(t1 + 20);
    wr(A_RUN, 16'h0001, 16'h1234, t2);
    expq.push_back(s + 10 + t2 - t1);
    wait_to(t2 + 12);
    wr(A_RUN, 16'h0000, 16'h1234, t1);

    // R8 smallest divisor (field 0), load 3
    wr(A_CFG, 16'h0000, 16'h1234, s);
    wr(A_LOAD, 16'h0003, 16'h1234, s);
    wr(A_REFR, 16'h0029, 16'h1234, s);
    wr(A_RUN, 16'h0001, 16'h1234, s);
    expq.push_back(s + 3); expq.push_back(s + 6); expq.push_back(s + 9);
    wait_to(s + 9);
    wr(A_RUN, 16'h0000, 16'h1234, t1);
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R8 all expected requests seen", expq.size(), 0);

    finish_run();
  end
endmodule